// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block brings a single-data-rate SDRAM from power-on to a usable state. After a synchronous reset it keeps clock enable high and holds a no-operation command on the bus for a programmable number of cycles. It then issues a precharge of every bank, a fixed number of auto-refresh commands and a write of the mode register. If the caller enables it, a write of the extended mode register follows, which selects how many banks are kept alive during self refresh. When the final settling wait has elapsed, it raises a completion flag, and the controller that owns normal traffic takes over the pins from that point.

Every wait is supplied as a cycle count on an input, so a single netlist can serve different clock rates. Counts that are too small for the memory are raised to a safe floor. All command pins are driven from registers.

Top module: `sdram_pwrup_seq`

## Requirements
- R1: While reset is high and on the first cycle after it, the bus shows a NOP (chip select low; row strobe, column strobe and write enable high), bank and address pins are zero, and `init_done` is low.
- R2: The precharge-all command appears exactly D_init cycles after the last clock edge at which reset is high, where D_init = `cyc_init`, or 1 if `cyc_init` is zero. Every cycle before it is a NOP.
- R3: Precharge-all is encoded as chip select, row strobe and write enable low with column strobe high. Address bit 10 is high and every other address bit and both bank pins are zero.
- R4: Exactly two auto-refresh commands follow. The first comes D_rp cycles after the precharge and the second comes D_rc cycles after the first. D_rp is `cyc_trp` and D_rc is `cyc_trc`, each raised to 1 if it is zero. Each refresh drives chip select and both strobes low with write enable high, and all bank and address pins zero.
- R5: The mode register write comes D_rc cycles after the last refresh. It drives all four command pins low and bank pins 00. The address carries `cfg_mode` with bits 7, 8, 10 and 11 forced to zero, so the kept mask is 0x27F.
- R6: When `emrs_en` is high, an extended mode write follows D_mrd cycles after the mode write. It uses bank pins 10 and carries the bank-retention code on address bits 2..0: 000 retains all four banks, 001 retains two and 010 retains one. Every other address bit is zero. Any other value of `cfg_pasr` is sent as 000.
- R7: When `emrs_en` is low, no command with bank pins 10 is issued.
- R8: D_mrd is `cyc_mrd`, raised to 2 if it is below 2. Any command that follows a mode or extended mode write comes at least two cycles after it.
- R9: `init_done` rises exactly D_mrd cycles after the final mode write. It then stays high until reset, and the bus shows only NOPs while it is high.
- R10: `sd_cke` is high in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_mode | input | ADDR_W | Mode register word |
| cfg_pasr | input | 3 | Bank-retention code for the extended mode write |
| emrs_en | input | 1 | Enables the extended mode write |
| cyc_init | input | CNT_W | Power-up NOP cycles |
| cyc_trp | input | CNT_W | Cycles from precharge to the first refresh |
| cyc_trc | input | CNT_W | Cycles between a refresh and the next command |
| cyc_mrd | input | CNT_W | Cycles after a mode write |
| sd_cke | output | 1 | Clock enable |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | 2 | Bank address |
| sd_addr | output | ADDR_W | Address |
| init_done | output | 1 | Initialization complete |

## Verification
The hardest cases to reach are the floors on the wait counts, where zero or one must still give legal spacing. A related case is back-to-back commands when every count is at its minimum, because the timer then reloads on consecutive edges. The stimulus reaches these by running whole sequences with all counts set to zero. It also uses an all-ones mode word and a reserved retention code, so that the sanitizing of the address fields can be seen on the pins. A scoreboard predicts the cycle of every command and of the rise of `init_done` from the requirement formulas, and compares it with the bus.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

  typedef enum logic [2:0] {
    CMD_NOP,
    CMD_PREALL,
    CMD_AREF,
    CMD_MODE,
    CMD_EXTMODE
  } cmd_e;

  typedef enum logic [2:0] {
    ST_PWR,
    ST_TRP,
    ST_TRC,
    ST_MRD,
    ST_EMD,
    ST_IDLE
  } st_e;

endpackage

// File: rtl/pwrup_wait_timer.sv
module pwrup_wait_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] rst_val,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expire
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= rst_val;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q > CNT_W'(1)) begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  assign expire = (cnt_q == CNT_W'(1));

endmodule

// File: rtl/pwrup_seq_fsm.sv
module pwrup_seq_fsm
  import sdram_init_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int N_REF = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             emrs_en,
  input  logic [CNT_W-1:0] cyc_init,
  input  logic [CNT_W-1:0] cyc_trp,
  input  logic [CNT_W-1:0] cyc_trc,
  input  logic [CNT_W-1:0] cyc_mrd,
  input  logic             expire,
  output logic [CNT_W-1:0] init_val,
  output logic             load,
  output logic [CNT_W-1:0] load_val,
  output cmd_e             cmd_nxt,
  output logic             done_set
);

  localparam int REF_W = $clog2(N_REF + 1);

  st_e              st_q, st_d;
  logic [REF_W-1:0] ref_q, ref_d;
  logic [CNT_W-1:0] d_rp, d_rc, d_mrd;

  assign init_val = (cyc_init == '0) ? CNT_W'(1) : cyc_init;
  assign d_rp     = (cyc_trp  == '0) ? CNT_W'(1) : cyc_trp;
  assign d_rc     = (cyc_trc  == '0) ? CNT_W'(1) : cyc_trc;
  assign d_mrd    = (cyc_mrd < CNT_W'(2)) ? CNT_W'(2) : cyc_mrd;

  always_comb begin
    st_d     = st_q;
    ref_d    = ref_q;
    load     = 1'b0;
    load_val = d_rc;
    cmd_nxt  = CMD_NOP;
    done_set = 1'b0;
    if (expire) begin
      case (st_q)
        ST_PWR: begin
          cmd_nxt  = CMD_PREALL;
          load     = 1'b1;
          load_val = d_rp;
          st_d     = ST_TRP;
        end
        ST_TRP: begin
          cmd_nxt  = CMD_AREF;
          load     = 1'b1;
          load_val = d_rc;
          ref_d    = REF_W'(1);
          st_d     = ST_TRC;
        end
        ST_TRC: begin
          load = 1'b1;
          if (ref_q < REF_W'(N_REF)) begin
            cmd_nxt  = CMD_AREF;
            load_val = d_rc;
            ref_d    = ref_q + REF_W'(1);
          end else begin
            cmd_nxt  = CMD_MODE;
            load_val = d_mrd;
            st_d     = ST_MRD;
          end
        end
        ST_MRD: begin
          if (emrs_en) begin
            cmd_nxt  = CMD_EXTMODE;
            load     = 1'b1;
            load_val = d_mrd;
            st_d     = ST_EMD;
          end else begin
            done_set = 1'b1;
            st_d     = ST_IDLE;
          end
        end
        ST_EMD: begin
          done_set = 1'b1;
          st_d     = ST_IDLE;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= ST_PWR;
      ref_q <= '0;
    end else begin
      st_q  <= st_d;
      ref_q <= ref_d;
    end
  end

  AST_MODE_GAP: assert property (@(posedge clk) disable iff (rst)
    (cmd_nxt == CMD_MODE || cmd_nxt == CMD_EXTMODE) |=> (cmd_nxt == CMD_NOP && !done_set)); // R8

  AST_REF_COUNT: assert property (@(posedge clk) disable iff (rst)
    (cmd_nxt == CMD_MODE) |-> (ref_q == REF_W'(N_REF))); // R4

  AST_DONE_ONCE: assert property (@(posedge clk) disable iff (rst)
    done_set |=> (!done_set && cmd_nxt == CMD_NOP)); // R9

  AST_NO_EXT_OFF: assert property (@(posedge clk) disable iff (rst)
    (!emrs_en && st_q == ST_MRD) |-> (cmd_nxt != CMD_EXTMODE)); // R7

endmodule

// File: rtl/pwrup_cmd_drive.sv
module pwrup_cmd_drive
  import sdram_init_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  cmd_e              cmd_nxt,
  input  logic              done_set,
  input  logic [ADDR_W-1:0] cfg_mode,
  input  logic [2:0]        cfg_pasr,
  output logic              sd_cke,
  output logic              sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic [1:0]        sd_ba,
  output logic [ADDR_W-1:0] sd_addr,
  output logic              init_done
);

  localparam int          AP_BIT    = 10;
  localparam [ADDR_W-1:0] MODE_KEEP = ADDR_W'(12'h27F);
  localparam [ADDR_W-1:0] AP_WORD   = ADDR_W'(1) << AP_BIT;

  logic [2:0]        pasr_ok;
  logic [3:0]        pins_d;
  logic [1:0]        ba_d;
  logic [ADDR_W-1:0] addr_d;

  assign pasr_ok = (cfg_pasr <= 3'd2) ? cfg_pasr : 3'd0;

  always_comb begin
    pins_d = 4'b0111;
    ba_d   = 2'b00;
    addr_d = '0;
    case (cmd_nxt)
      CMD_PREALL: begin
        pins_d = 4'b0010;
        addr_d = AP_WORD;
      end
      CMD_AREF:   pins_d = 4'b0001;
      CMD_MODE: begin
        pins_d = 4'b0000;
        addr_d = cfg_mode & MODE_KEEP;
      end
      CMD_EXTMODE: begin
        pins_d = 4'b0000;
        ba_d   = 2'b10;
        addr_d = {{(ADDR_W-3){1'b0}}, pasr_ok};
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sd_cke    <= 1'b1;
      {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} <= 4'b0111;
      sd_ba     <= 2'b00;
      sd_addr   <= '0;
      init_done <= 1'b0;
    end else begin
      sd_cke    <= 1'b1;
      {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} <= pins_d;
      sd_ba     <= ba_d;
      sd_addr   <= addr_d;
      init_done <= init_done | done_set;
    end
  end

  AST_MODE_RSVD: assert property (@(posedge clk) disable iff (rst)
    ({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b0000 && sd_ba == 2'b00)
      |-> ((sd_addr & ~MODE_KEEP) == '0)); // R5

  AST_EXT_CODE: assert property (@(posedge clk) disable iff (rst)
    ({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b0000 && sd_ba == 2'b10)
      |-> (sd_addr[ADDR_W-1:3] == '0 && sd_addr[2:0] <= 3'd2)); // R6

  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (rst)
    init_done |-> ({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b0111)); // R9

  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (rst)
    init_done |=> init_done); // R9

  AST_CKE_HIGH: assert property (@(posedge clk) disable iff (rst)
    !rst |=> sd_cke); // R10

endmodule

// File: rtl/sdram_pwrup_seq.sv
module sdram_pwrup_seq
  import sdram_init_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int CNT_W  = 16,
  parameter int N_REF  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] cfg_mode,
  input  logic [2:0]        cfg_pasr,
  input  logic              emrs_en,
  input  logic [CNT_W-1:0]  cyc_init,
  input  logic [CNT_W-1:0]  cyc_trp,
  input  logic [CNT_W-1:0]  cyc_trc,
  input  logic [CNT_W-1:0]  cyc_mrd,
  output logic              sd_cke,
  output logic              sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic [1:0]        sd_ba,
  output logic [ADDR_W-1:0] sd_addr,
  output logic              init_done
);

  logic             expire, load, done_set;
  logic [CNT_W-1:0] init_val, load_val;
  cmd_e             cmd_nxt;

  pwrup_wait_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .rst_val  (init_val),
    .load     (load),
    .load_val (load_val),
    .expire   (expire)
  );

  pwrup_seq_fsm #(.CNT_W(CNT_W), .N_REF(N_REF)) u_fsm (
    .clk      (clk),
    .rst      (rst),
    .emrs_en  (emrs_en),
    .cyc_init (cyc_init),
    .cyc_trp  (cyc_trp),
    .cyc_trc  (cyc_trc),
    .cyc_mrd  (cyc_mrd),
    .expire   (expire),
    .init_val (init_val),
    .load     (load),
    .load_val (load_val),
    .cmd_nxt  (cmd_nxt),
    .done_set (done_set)
  );

  pwrup_cmd_drive #(.ADDR_W(ADDR_W)) u_drive (
    .clk       (clk),
    .rst       (rst),
    .cmd_nxt   (cmd_nxt),
    .done_set  (done_set),
    .cfg_mode  (cfg_mode),
    .cfg_pasr  (cfg_pasr),
    .sd_cke    (sd_cke),
    .sd_cs_n   (sd_cs_n),
    .sd_ras_n  (sd_ras_n),
    .sd_cas_n  (sd_cas_n),
    .sd_we_n   (sd_we_n),
    .sd_ba     (sd_ba),
    .sd_addr   (sd_addr),
    .init_done (init_done)
  );

endmodule

// File: tb/sdram_pwrup_seq_tb.sv
`timescale 1ns/100ps
module sdram_pwrup_seq_tb;

  localparam int ADDR_W = 12;
  localparam int CNT_W  = 16;

  typedef struct {
    int         cyc;
    int         kind;  // 1 pre, 2 refresh, 3 mode, 4 ext mode, 5 done
    logic [3:0] pins;
    logic [1:0] ba;
    logic [11:0] addr;
    string      req;
  } item_t;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [ADDR_W-1:0] cfg_mode = '0;
  logic [2:0]        cfg_pasr = '0;
  logic              emrs_en = 1'b0;
  logic [CNT_W-1:0]  cyc_init = 16'd3, cyc_trp = 16'd1, cyc_trc = 16'd1, cyc_mrd = 16'd2;
  logic              sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, init_done;
  logic [1:0]        sd_ba;
  logic [ADDR_W-1:0] sd_addr;

  int    n_tests = 0;
  int    n_fail  = 0;
  int    cyc     = 0;
  int    cke_bad = 0;
  logic  prev_done = 1'b0;
  item_t exp_q[$];

  always #2.5 clk = ~clk;

  sdram_pwrup_seq u_dut (
    .clk(clk), .rst(rst), .cfg_mode(cfg_mode), .cfg_pasr(cfg_pasr), .emrs_en(emrs_en),
    .cyc_init(cyc_init), .cyc_trp(cyc_trp), .cyc_trc(cyc_trc), .cyc_mrd(cyc_mrd),
    .sd_cke(sd_cke), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n),
    .sd_we_n(sd_we_n), .sd_ba(sd_ba), .sd_addr(sd_addr), .init_done(init_done)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic push(input int c, input int kind, input logic [3:0] pins,
                      input logic [1:0] ba, input logic [11:0] addr, input string req);
    item_t it;
    it.cyc = c; it.kind = kind; it.pins = pins; it.ba = ba; it.addr = addr; it.req = req;
    exp_q.push_back(it);
  endtask

  // Monitor: compares every non-NOP bus cycle and the rise of init_done
  always @(negedge clk) begin
    logic [3:0] pins;
    pins = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
    if (rst) begin
      cyc = 0;
    end else begin
      cyc++;
      if (sd_cke !== 1'b1) cke_bad++;
      if (pins !== 4'b0111) begin
        if (exp_q.size() == 0 || exp_q[0].kind == 5) begin
          check(1'b0, "R9", "unexpected command pins", int'(pins), 7);
        end else begin
          item_t it;
          it = exp_q.pop_front();
          check(cyc == it.cyc, it.req, "command cycle", cyc, it.cyc);
          check(pins === it.pins && sd_ba === it.ba && sd_addr === it.addr, it.req,
                "pins/ba/addr", int'({pins, sd_ba, sd_addr}), int'({it.pins, it.ba, it.addr}));
        end
      end
      if (init_done && !prev_done) begin
        if (exp_q.size() == 0 || exp_q[0].kind != 5) begin
          check(1'b0, "R9", "early init_done", cyc, -1);
        end else begin
          item_t it;
          it = exp_q.pop_front();
          check(cyc == it.cyc, "R9", "init_done rise cycle", cyc, it.cyc);
        end
      end
      if (!init_done && prev_done) check(1'b0, "R9", "init_done fell", 0, 1);
    end
    prev_done = init_done;
  end

  task automatic run_case(input int init, input int rp, input int rc, input int mrd,
                          input bit en, input logic [11:0] mode, input logic [2:0] pasr);
    int t, d_rc, d_mrd;
    logic [2:0] code;
    @(negedge clk); #1;
    rst = 1'b1;
    cyc_init = CNT_W'(init); cyc_trp = CNT_W'(rp); cyc_trc = CNT_W'(rc); cyc_mrd = CNT_W'(mrd);
    emrs_en = en; cfg_mode = mode; cfg_pasr = pasr;
    repeat (3) @(negedge clk);
    // R1: reset state
    check({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} === 4'b0111 && sd_ba === 2'b00 && sd_addr === '0,
          "R1", "reset bus", int'({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_ba, sd_addr}), 32'h1C000);
    check(init_done === 1'b0 && sd_cke === 1'b1, "R1", "reset done/cke",
          int'({init_done, sd_cke}), 1);
    // expected timeline (R2..R9)
    d_rc  = (rc == 0) ? 1 : rc;
    d_mrd = (mrd < 2) ? 2 : mrd;
    t = (init == 0) ? 1 : init;
    push(t, 1, 4'b0010, 2'b00, 12'h400, "R2_R3 precharge");
    t += (rp == 0) ? 1 : rp;
    push(t, 2, 4'b0001, 2'b00, 12'h000, "R4 refresh1");
    t += d_rc;
    push(t, 2, 4'b0001, 2'b00, 12'h000, "R4 refresh2");
    t += d_rc;
    push(t, 3, 4'b0000, 2'b00, mode & 12'h27F, "R5 mode");
    t += d_mrd;
    if (en) begin
      code = (pasr <= 3'd2) ? pasr : 3'd0;
      push(t, 4, 4'b0000, 2'b10, {9'd0, code}, "R6_R8 ext mode");
      t += d_mrd;
    end
    push(t, 5, 4'b0111, 2'b00, 12'h000, "R9 done");
    cke_bad = 0;
    #1 rst = 1'b0;
    while (exp_q.size() != 0) @(negedge clk);
    repeat (20) @(negedge clk);
    check(init_done === 1'b1, "R9", "done held", int'(init_done), 1);
    check(cke_bad == 0, "R10", "cke low cycles", cke_bad, 0);
  endtask

  initial begin
    run_case(5, 2, 3, 2, 1'b0, 12'h032, 3'd0);   // R7: no ext mode write
    run_case(0, 0, 0, 0, 1'b1, 12'hFFF, 3'd1);   // R8 floors, R5 mask
    run_case(20, 4, 6, 4, 1'b1, 12'h5A5, 3'd6);  // R6 reserved code
    run_case(1, 1, 1, 1, 1'b1, 12'h223, 3'd2);   // R6 one bank
    run_case(9, 3, 7, 5, 1'b0, 12'hC80, 3'd1);   // R7 code ignored when disabled
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule